// File: doc/BRIEF.md
# Windowed RSSI Busy-Channel Trigger

This block decides when a radio channel is occupied. Each accepted sample beat carries one signal-strength word from each of four RF lanes. A per-lane enable mask picks which lanes count, and the enabled words of a beat are added into one combined value. A circular buffer keeps the most recent combined values. A running sum covers the last L of them, where L is a configurable window length of up to 32 beats.

The raw windowed sum is compared against a threshold. It is not divided by L. The detector counts consecutive beats on which the sum is strictly above the threshold. When that count reaches a configured minimum, it emits a one-cycle trigger pulse. It then stays disarmed until the sum falls back to or below the threshold.

The sample input is a valid/ready stream in the logic clock domain. The crossing from the sampling clock has already been reduced to this strobe by the surrounding logic. `smp_ready` is high on every cycle except one: the cycle in which a changed window length is first seen. In that cycle the window is flushed and no beat is taken. The source must hold `smp_valid` and `smp_data` until it sees `smp_ready` high.

Top module: `busy_energy_detect`

## Requirements
- R1: A beat is accepted on a rising clock edge where `smp_valid` and `smp_ready` are both high. `smp_ready` is low only in a cycle where the effective window length differs from the one in use, and it returns high on the next cycle.
- R2: Lane k occupies `smp_data[10k+9:10k]`, with lane A at k=0. Each lane word is a 10-bit unsigned value. The combined value of a beat is the sum of the lanes whose bit k of `cfg_lane_mask` is 1. The data on lanes whose mask bit is 0 has no effect on any output.
- R3: The effective window length L is `cfg_win_len`, with two exceptions. A value of 0 gives L=1, and a value above 32 gives L=32. The windowed sum is the sum of the last L combined values.
- R4: A beat is busy when the window holds L values and the windowed sum is strictly greater than `cfg_thresh`. A sum equal to the threshold is not busy.
- R5: `trig_pulse` is high for exactly one cycle when the count of consecutive busy beats reaches `cfg_min_busy`, with a value of 0 treated as 1. The pulse is visible in the cycle after the edge that follows the accepting edge.
- R6: After a pulse, the detector produces no further pulse until a non-busy beat has been accepted. That beat also resets the busy count.
- R7: A change of the effective window length empties the buffer, the sum and the busy count, and re-arms the detector. No beat is busy until L new beats have been accepted.
- R8: After reset, `trig_pulse` is 0, `smp_ready` is 1 when L is 1, and the window is empty.
- R9: The windowed sum register is 17 bits wide, so it can never overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | logic clock |
| rst_n | input | 1 | active-low synchronous reset |
| smp_valid | input | 1 | sample beat valid |
| smp_ready | output | 1 | sample beat ready (low during window flush) |
| smp_data | input | 40 | four 10-bit lane words, lane A in the low bits |
| cfg_lane_mask | input | 4 | lane enable mask, bit k for lane k |
| cfg_win_len | input | 6 | window length in beats |
| cfg_thresh | input | 17 | busy threshold on the windowed sum |
| cfg_min_busy | input | 8 | consecutive busy beats needed to fire |
| trig_pulse | output | 1 | one-cycle busy trigger |

## Verification
The hardest state to reach from the ports is a length change that lands while the detector is disarmed or partway through a busy run. A change to L=1 makes the very first new beat eligible, so any busy count carried over from before would surface at once. To get there, the bench walks a list of window lengths without resetting between them. Each length is driven with alternating loud and quiet bursts on every lane mask. One entry in the list is an over-range value that clamps to the length already in use, which checks that a clamped value causes no flush.

// File: rtl/rssi_pkg.sv
package rssi_pkg;
  localparam int DEF_SMP_W   = 10;
  localparam int DEF_LANES   = 4;
  localparam int DEF_MAX_WIN = 32;
  localparam int DEF_CNT_W   = 8;
endpackage

// File: rtl/lane_combiner.sv
module lane_combiner #(
  parameter int SMP_W = rssi_pkg::DEF_SMP_W,
  parameter int LANES = rssi_pkg::DEF_LANES,
  localparam int CMB_W = SMP_W + $clog2(LANES)
) (
  input  logic [SMP_W*LANES-1:0] lanes_i,
  input  logic [LANES-1:0]       mask_i,
  output logic [CMB_W-1:0]       cmb_o
);
  logic [CMB_W-1:0] gated [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign gated[k] = mask_i[k] ? CMB_W'(lanes_i[k*SMP_W +: SMP_W]) : '0;
  end

  always_comb begin
    cmb_o = '0;
    for (int k = 0; k < LANES; k++) cmb_o = cmb_o + gated[k];
  end
endmodule

// File: rtl/moving_window.sv
module moving_window #(
  parameter int CMB_W   = 12,
  parameter int MAX_WIN = rssi_pkg::DEF_MAX_WIN,
  parameter int CMB_MAX = 4092,
  localparam int LEN_W  = $clog2(MAX_WIN) + 1,
  localparam int PTR_W  = $clog2(MAX_WIN),
  localparam int SUM_W  = CMB_W + $clog2(MAX_WIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_cfg_i,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [CMB_W-1:0] cmb_i,
  output logic             clr_o,
  output logic             step_o,
  output logic             full_o,
  output logic [SUM_W-1:0] sum_o
);
  logic [CMB_W-1:0] ring [MAX_WIN];
  logic [LEN_W-1:0] eff_len, len_q, fill_q, fill_nx;
  logic [PTR_W-1:0] ptr_q;
  logic [SUM_W-1:0] sum_q, old_val;
  logic             step_q, full_q, accept;

  always_comb begin
    if (len_cfg_i == '0)                  eff_len = LEN_W'(1);
    else if (len_cfg_i > LEN_W'(MAX_WIN)) eff_len = LEN_W'(MAX_WIN);
    else                                  eff_len = len_cfg_i;
  end

  assign clr_o   = (eff_len != len_q);
  assign ready_o = !clr_o;
  assign accept  = valid_i && ready_o;
  assign old_val = (fill_q == len_q) ? SUM_W'(ring[ptr_q]) : '0;
  assign fill_nx = (fill_q < len_q) ? fill_q + LEN_W'(1) : fill_q;

  always_ff @(posedge clk) begin
    if (accept) ring[ptr_q] <= cmb_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(1);
      fill_q <= '0;
      ptr_q  <= '0;
      sum_q  <= '0;
      step_q <= 1'b0;
      full_q <= 1'b0;
    end else if (clr_o) begin
      len_q  <= eff_len;
      fill_q <= '0;
      ptr_q  <= '0;
      sum_q  <= '0;
      step_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      step_q <= accept;
      if (accept) begin
        sum_q  <= sum_q + SUM_W'(cmb_i) - old_val;
        fill_q <= fill_nx;
        full_q <= (fill_nx == len_q);
        ptr_q  <= (LEN_W'(ptr_q) == len_q - LEN_W'(1)) ? '0 : ptr_q + PTR_W'(1);
      end
    end
  end

  assign step_o = step_q;
  assign full_o = full_q;
  assign sum_o  = sum_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= len_q); // R3
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |=> (fill_q == '0 && sum_q == '0 && !step_o)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sum_q) <= int'(fill_q) * CMB_MAX); // R9
endmodule

// File: rtl/busy_qualifier.sv
module busy_qualifier #(
  parameter int SUM_W = 17,
  parameter int CNT_W = rssi_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             full_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [SUM_W-1:0] thr_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             trig_o
);
  logic [CNT_W-1:0] cnt_q, min_eff;
  logic             armed_q, trig_q, busy;

  assign min_eff = (min_i == '0) ? CNT_W'(1) : min_i;
  assign busy    = full_i && (sum_i > thr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (clr_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (step_i) begin
        if (!busy) begin
          cnt_q   <= '0;
          armed_q <= 1'b1;
        end else if (armed_q) begin
          if (cnt_q + CNT_W'(1) >= min_eff) begin
            trig_q  <= 1'b1;
            armed_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
      end
    end
  end

  assign trig_o = trig_q;

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q); // R5
  AST_TRIG_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_q) |-> $past(step_i && full_i && (sum_i > thr_i))); // R4
  AST_DISARMED_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> !armed_q); // R6
endmodule

// File: rtl/busy_energy_detect.sv
module busy_energy_detect #(
  parameter int SMP_W   = rssi_pkg::DEF_SMP_W,
  parameter int LANES   = rssi_pkg::DEF_LANES,
  parameter int MAX_WIN = rssi_pkg::DEF_MAX_WIN,
  parameter int CNT_W   = rssi_pkg::DEF_CNT_W,
  localparam int CMB_W   = SMP_W + $clog2(LANES),
  localparam int LEN_W   = $clog2(MAX_WIN) + 1,
  localparam int SUM_W   = CMB_W + $clog2(MAX_WIN),
  localparam int CMB_MAX = LANES * ((1 << SMP_W) - 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  output logic                   smp_ready,
  input  logic [SMP_W*LANES-1:0] smp_data,
  input  logic [LANES-1:0]       cfg_lane_mask,
  input  logic [LEN_W-1:0]       cfg_win_len,
  input  logic [SUM_W-1:0]       cfg_thresh,
  input  logic [CNT_W-1:0]       cfg_min_busy,
  output logic                   trig_pulse
);
  logic [CMB_W-1:0] cmb;
  logic [SUM_W-1:0] win_sum;
  logic             win_clr, win_step, win_full;

  lane_combiner #(.SMP_W(SMP_W), .LANES(LANES)) i_comb (
    .lanes_i(smp_data), .mask_i(cfg_lane_mask), .cmb_o(cmb)
  );

  moving_window #(.CMB_W(CMB_W), .MAX_WIN(MAX_WIN), .CMB_MAX(CMB_MAX)) i_win (
    .clk(clk), .rst_n(rst_n), .len_cfg_i(cfg_win_len), .valid_i(smp_valid),
    .ready_o(smp_ready), .cmb_i(cmb), .clr_o(win_clr), .step_o(win_step),
    .full_o(win_full), .sum_o(win_sum)
  );

  busy_qualifier #(.SUM_W(SUM_W), .CNT_W(CNT_W)) i_qual (
    .clk(clk), .rst_n(rst_n), .clr_i(win_clr), .step_i(win_step),
    .full_i(win_full), .sum_i(win_sum), .thr_i(cfg_thresh),
    .min_i(cfg_min_busy), .trig_o(trig_pulse)
  );

  AST_READY_RECOVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && $stable(cfg_win_len)) |=> smp_ready); // R1
endmodule

// File: tb/test_busy_energy_detect.sv
module test_busy_energy_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [39:0] smp_data = '0;
  logic [3:0]  cfg_lane_mask = 4'hF;
  logic [5:0]  cfg_win_len = 6'd1;
  logic [16:0] cfg_thresh = '0;
  logic [7:0]  cfg_min_busy = 8'd1;
  logic        trig_pulse;

  int total = 0, bad = 0, fires = 0;
  int hist [32];
  int mfill = 0, mlen = 1, mcnt = 0;
  bit marmed = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  busy_energy_detect i_busy_energy_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cfg_lane_mask(cfg_lane_mask), .cfg_win_len(cfg_win_len),
    .cfg_thresh(cfg_thresh), .cfg_min_busy(cfg_min_busy), .trig_pulse(trig_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_of(input int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr);
  endfunction

  task automatic set_len(input int v);
    int e = eff_of(v);
    @(negedge clk);
    cfg_win_len = 6'(v);
    #1;
    if (e != mlen) begin
      chk("R1 ready low on length change", int'(smp_ready), 0);
      @(posedge clk); #1;
      chk("R7 ready back after flush", int'(smp_ready), 1);
      mlen = e; mfill = 0; mcnt = 0; marmed = 1'b1;
    end else begin
      chk("R1 ready stays high on same effective length", int'(smp_ready), 1);
    end
  endtask

  task automatic send_beat(input logic [39:0] d);
    int cmb = 0, sum = 0, mb;
    bit busy, exp_t = 1'b0;
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    @(posedge clk); #1;
    smp_valid = 1'b0;
    chk("R5 no pulse on accept edge", int'(trig_pulse), 0);
    for (int k = 0; k < 4; k++) if (cfg_lane_mask[k]) cmb += int'(d[k*10 +: 10]);
    for (int k = 31; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = cmb;
    if (mfill < mlen) mfill++;
    for (int k = 0; k < mlen; k++) sum += hist[k];
    busy = (mfill == mlen) && (sum > int'(cfg_thresh));
    mb = (cfg_min_busy == 0) ? 1 : int'(cfg_min_busy);
    if (!busy) begin
      mcnt = 0; marmed = 1'b1;
    end else if (marmed) begin
      mcnt++;
      if (mcnt >= mb) begin exp_t = 1'b1; marmed = 1'b0; end
    end
    @(posedge clk); #1;
    chk("R2 R3 R4 R5 R6 pulse vs model", int'(trig_pulse), int'(exp_t));
    if (trig_pulse) fires++;
  endtask

  initial begin
    int lens [7] = '{1, 3, 8, 32, 40, 0, 5};
    repeat (3) @(posedge clk);
    #1;
    chk("R8 trig low in reset", int'(trig_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R8 ready high after reset", int'(smp_ready), 1);
    // R2: threshold 0 with mask 0 must never fire even with loud lanes
    cfg_lane_mask = 4'h0; cfg_thresh = '0; cfg_min_busy = 8'd1;
    for (int i = 0; i < 4; i++) send_beat({4{10'h3FF}});
    // R4: sum equal to threshold is not busy, one above is
    cfg_lane_mask = 4'h1; cfg_thresh = 17'd500;
    send_beat({30'd0, 10'd500});
    send_beat({30'd0, 10'd501});
    foreach (lens[li]) begin
      set_len(lens[li]);
      for (int m = 0; m < 16; m++) begin
        int nsel = $countones(4'(m));
        cfg_lane_mask = 4'(m);
        cfg_thresh = 17'(eff_of(lens[li]) * nsel * 500);
        cfg_min_busy = 8'(m % 5);
        for (int i = 0; i < 26; i++) begin
          logic [39:0] d;
          for (int k = 0; k < 4; k++) begin
            int r = next_rand() % 100;
            d[k*10 +: 10] = ((i / 9) % 2 == 0) ? 10'(900 + r) : 10'(r);
          end
          send_beat(d);
        end
      end
    end
    total++;
    if (fires == 0) begin
      bad++;
      $display("FAIL R5 no triggers seen actual=0 expected>0");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule